// File: doc/BRIEF.md
# Dual-Clock Parity-Checking FIFO with Rewind

This block is a first-in first-out buffer for 18-bit words that sits between two clock domains. A producer pushes words on its own clock with an active-low write enable, and a consumer pulls them on an independent read clock with an active-low read enable. Each word holds two 9-bit byte lanes. Each lane has 8 data bits and one parity bit. Both parity bits are stored and returned with the data.

On the read side the block checks the 8 data bits of each lane of the word currently presented. It raises one error flag per lane. The sense of the check, even or odd, is captured from a configuration pin while reset is held. The block reports empty, full and half-full status. An output enable floats the data pins without disturbing anything else. A rewind request sends the read pointer back to the slot that received the first write after reset, so that the stored stream can be replayed. A flag-valid output then stays low for a fixed number of read cycles while the status settles.

Top module: `pfifo`

## Requirements
- R1: While reset is held and after its release, before any write, empty is 1, full is 0, half_full is 0, flags_ok is 1 and q is 0.
- R2: Words come out in the order they were written. q changes at a read clock rising edge where ren_n is 0 and the FIFO is not empty, and it then shows the next stored word.
- R3: At a read clock edge with ren_n high, q, pe and the read position all hold.
- R4: A read request while empty is ignored: q keeps the last word and no word is consumed.
- R5: full rises once DEPTH words are stored. A write while full is dropped, so draining returns exactly the DEPTH earlier words.
- R6: half_full is 1 when the write-side count of stored words is at least DEPTH/2, and 0 below that.
- R7: pe[0] checks q[7:0] and pe[1] checks q[16:9]. q[8] and q[17] take no part in the check. In even mode a flag is 1 when its lane holds an odd number of ones.
- R8: The odd_sel level present during reset selects odd mode (1) or even mode (0). In odd mode a flag is 1 when its lane holds an even number of ones, and changing odd_sel after reset has no effect.
- R9: pe follows the word on q. It changes only when q changes, and it does not depend on oe_n.
- R10: With oe_n high, q_oe is 0 and q floats. oe_n does not stop reads or move the read position, and q_oe is 1 when oe_n is low.
- R11: A rewind request (rt_req high at a read clock edge) with no write activity seen in the read domain sets the read position back to the first slot written after reset. The following reads replay the stream from there. A request made while writes are active is ignored.
- R12: After an accepted rewind, flags_ok is 0 for RT_CYC read clock edges, counting the accepting edge, and returns to 1 at the edge after those.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| odd_sel | input | 1 | Parity sense, sampled while reset is held: 1 odd, 0 even |
| wen_n | input | 1 | Active-low write enable |
| d | input | 18 | Write data, parity bits at 8 and 17 |
| ren_n | input | 1 | Active-low read enable |
| rt_req | input | 1 | Rewind request, read clock domain |
| oe_n | input | 1 | Active-low output enable for q |
| q | output | 18 | Read data, floats when oe_n is high |
| q_oe | output | 1 | High while q is driven |
| pe | output | 2 | Per-lane parity error, bit 0 for the low lane |
| empty | output | 1 | No word available, read domain |
| full | output | 1 | No space left, write domain |
| half_full | output | 1 | At least DEPTH/2 words stored, write domain |
| flags_ok | output | 1 | Low during rewind recovery |

## Verification
Some rules are checked on every clock: dropped writes while full, ignored reads while empty, output and error-flag hold when the read enable is idle, and the read position returning to the first slot whenever flag-valid falls. The bench scenarios cover the rest. These are the per-lane parity results under both senses, including the stored parity bits being excluded from the check, the exact half-full and full thresholds, and replay order after a rewind. They also cover the refusal of a rewind during active writes, the length of the recovery window, and the output enable leaving the read stream intact.

// File: rtl/pfifo.sv
module pfifo #(
  parameter int DEPTH  = 512,
  parameter int RT_CYC = 4
) (
  input  logic        wclk,
  input  logic        rclk,
  input  logic        rst_n,
  input  logic        odd_sel,
  input  logic        wen_n,
  input  logic [17:0] d,
  input  logic        ren_n,
  input  logic        rt_req,
  input  logic        oe_n,
  output logic [17:0] q,
  output logic        q_oe,
  output logic [1:0]  pe,
  output logic        empty,
  output logic        full,
  output logic        half_full,
  output logic        flags_ok
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(RT_CYC + 1);
  localparam logic [AW:0] MARK = '0;

  function automatic logic [AW:0] b2g(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [17:0]  mem [DEPTH];
  logic [AW:0]  wbin, wgray, rbin, rgray;
  logic [AW:0]  wq1, wq2, rq1, rq2;
  logic [AW:0]  wlevel;
  logic [17:0]  qreg;
  logic [CW-1:0] rt_cnt;
  logic         wact1, wact2, odd_q;
  logic         wr_go, rd_go, rt_go;

  assign wr_go = !wen_n && !full;
  assign rt_go = rt_req && !wact2;
  assign rd_go = !ren_n && !empty && !rt_go;

  always_ff @(posedge wclk)
    if (wr_go) mem[wbin[AW-1:0]] <= d;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rq1   <= '0;
      rq2   <= '0;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      if (wr_go) begin
        wbin  <= wbin + 1'b1;
        wgray <= b2g(wbin + 1'b1);
      end
    end

  assign full      = (wgray == {~rq2[AW:AW-1], rq2[AW-2:0]});
  assign wlevel    = wbin - g2b(rq2);
  assign half_full = (wlevel >= (AW+1)'(DEPTH / 2));

  always_ff @(posedge rclk)
    if (!rst_n) odd_q <= odd_sel;

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rbin   <= '0;
      rgray  <= '0;
      wq1    <= '0;
      wq2    <= '0;
      wact1  <= 1'b0;
      wact2  <= 1'b0;
      qreg   <= '0;
      rt_cnt <= '0;
    end else begin
      wq1   <= wgray;
      wq2   <= wq1;
      wact1 <= !wen_n;
      wact2 <= wact1;
      if (rt_go) begin
        rbin  <= MARK;
        rgray <= b2g(MARK);
      end else if (rd_go) begin
        rbin  <= rbin + 1'b1;
        rgray <= b2g(rbin + 1'b1);
        qreg  <= mem[rbin[AW-1:0]];
      end
      if (rt_go) rt_cnt <= CW'(RT_CYC);
      else if (rt_cnt != '0) rt_cnt <= rt_cnt - 1'b1;
    end

  assign empty    = (rgray == wq2);
  assign flags_ok = (rt_cnt == '0);

  assign pe[0] = ^qreg[7:0]  ^ odd_q;
  assign pe[1] = ^qreg[16:9] ^ odd_q;

  assign q_oe = !oe_n;
  assign q    = oe_n ? 'z : qreg;
endmodule

module pfifo_chk #(
  parameter int AW = 9
) (
  input logic        wclk,
  input logic        rclk,
  input logic        rst_n,
  input logic        wen_n,
  input logic        ren_n,
  input logic        rt_req,
  input logic        full,
  input logic        empty,
  input logic        flags_ok,
  input logic [1:0]  pe,
  input logic [AW:0] wbin,
  input logic [AW:0] rbin,
  input logic [17:0] qreg
);
  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
    full && !wen_n |=> $stable(wbin)); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
    empty && !ren_n && !rt_req |=> $stable(rbin) && $stable(qreg)); // R4
  AST_HOLD_IDLE: assert property (@(posedge rclk) disable iff (!rst_n)
    ren_n |=> $stable(qreg)); // R3
  AST_PE_FOLLOWS_Q: assert property (@(posedge rclk) disable iff (!rst_n)
    ren_n |=> $stable(pe)); // R9
  AST_RT_REWIND: assert property (@(posedge rclk) disable iff (!rst_n)
    $fell(flags_ok) |-> rbin == '0); // R11
endmodule

bind pfifo pfifo_chk #(.AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen_n(wen_n), .ren_n(ren_n),
  .rt_req(rt_req), .full(full), .empty(empty), .flags_ok(flags_ok),
  .pe(pe), .wbin(wbin), .rbin(rbin), .qreg(qreg)
);

// File: tb/pfifo_tb.sv
`timescale 1ns/1ps
module pfifo_tb;
  localparam int DEPTH  = 512;
  localparam int RT_CYC = 4;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0, odd_sel = 1'b0;
  logic wen_n = 1'b1, ren_n = 1'b1, rt_req = 1'b0, oe_n = 1'b0;
  logic [17:0] d = '0;
  logic [17:0] q;
  logic [1:0]  pe;
  logic q_oe, empty, full, half_full, flags_ok;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  // {expected pe in even mode, data}
  localparam logic [19:0] VEC [8] = '{
    {2'b00, 18'h00000}, {2'b01, 18'h00001}, {2'b10, 18'h00200},
    {2'b00, 18'h20100}, {2'b00, 18'h1FEFF}, {2'b01, 18'h00007},
    {2'b00, 18'h3FFFF}, {2'b11, 18'h0FE01}
  };

  pfifo #(.DEPTH(DEPTH), .RT_CYC(RT_CYC)) u_dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .odd_sel(odd_sel),
    .wen_n(wen_n), .d(d), .ren_n(ren_n), .rt_req(rt_req), .oe_n(oe_n),
    .q(q), .q_oe(q_oe), .pe(pe), .empty(empty), .full(full),
    .half_full(half_full), .flags_ok(flags_ok)
  );

  always #2.5 wclk = ~wclk;
  initial begin #1.3; forever #2.5 rclk = ~rclk; end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic odd);
    rst_n = 1'b0; odd_sel = odd; wen_n = 1'b1; ren_n = 1'b1; rt_req = 1'b0; oe_n = 1'b0;
    repeat (4) @(posedge rclk);
    @(negedge wclk) rst_n = 1'b1;
    repeat (3) @(posedge rclk);
    #1;
  endtask

  task automatic wr(input logic [17:0] x);
    @(negedge wclk); wen_n = 1'b0; d = x;
    @(posedge wclk); #1 wen_n = 1'b1;
  endtask

  task automatic rd();
    @(negedge rclk); ren_n = 1'b0;
    @(posedge rclk); #1 ren_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge rclk);
    #1;
  endtask

  task automatic rewind();
    @(negedge rclk); rt_req = 1'b1;
    @(posedge rclk); #1 rt_req = 1'b0;
  endtask

  initial begin
    do_reset(1'b0);
    chk(empty == 1'b1, "R1 empty", empty, 1);
    chk(full == 1'b0, "R1 full", full, 0);
    chk(half_full == 1'b0, "R1 half_full", half_full, 0);
    chk(flags_ok == 1'b1, "R1 flags_ok", flags_ok, 1);
    chk(q == 18'h0, "R1 q", q, 0);
    chk(pe == 2'b00, "R1 pe", pe, 0);

    foreach (VEC[i]) wr(VEC[i][17:0]);
    idle(6);
    foreach (VEC[i]) begin
      rd();
      chk(q == VEC[i][17:0], "R2 order", q, VEC[i][17:0]);
      chk(pe == VEC[i][19:18], "R7 lane parity even", pe, VEC[i][19:18]);
    end

    idle(5);
    chk(q == 18'h0FE01, "R3 q holds idle", q, 18'h0FE01);
    chk(pe == 2'b11, "R3 pe holds idle", pe, 2'b11);
    chk(empty == 1'b1, "R4 empty after drain", empty, 1);
    rd();
    chk(q == 18'h0FE01, "R4 read on empty ignored", q, 18'h0FE01);

    for (int i = 0; i < DEPTH; i++) begin
      wr(18'(i));
      if (i == DEPTH/2 - 2) chk(half_full == 1'b0, "R6 below half", half_full, 0);
      if (i == DEPTH/2 - 1) chk(half_full == 1'b1, "R6 at half", half_full, 1);
      if (i == DEPTH - 2)   chk(full == 1'b0, "R5 one below full", full, 0);
    end
    chk(full == 1'b1, "R5 full at DEPTH", full, 1);
    wr(18'h3ABCD);
    chk(full == 1'b1, "R5 still full", full, 1);
    idle(6);
    begin
      int bad = 0;
      for (int i = 0; i < DEPTH; i++) begin
        rd();
        if (q != 18'(i)) bad++;
      end
      chk(bad == 0, "R5 drained words in order", bad, 0);
    end
    chk(empty == 1'b1, "R5 empty after DEPTH reads", empty, 1);
    rd();
    chk(q == 18'(DEPTH-1), "R5 dropped word absent", q, DEPTH-1);
    idle(6);
    chk(half_full == 1'b0, "R6 cleared after drain", half_full, 0);

    // R10 output enable
    wr(18'h2AAAA); wr(18'h15555);
    idle(6);
    @(negedge rclk) oe_n = 1'b1;
    #1;
    chk(q_oe == 1'b0, "R10 q_oe low", q_oe, 0);
    chk(pe == 2'b00, "R9 pe independent of oe_n", pe, 2'b00);
    rd();
    @(negedge rclk) oe_n = 1'b0;
    #1;
    chk(q_oe == 1'b1, "R10 q_oe high", q_oe, 1);
    chk(q == 18'h2AAAA, "R10 read while floated", q, 18'h2AAAA);
    rd();
    chk(q == 18'h15555, "R10 order intact", q, 18'h15555);

    // R11 / R12 rewind
    do_reset(1'b0);
    for (int i = 0; i < 6; i++) wr(18'h01000 + 18'(i));
    idle(6);
    for (int i = 0; i < 3; i++) begin
      rd();
      chk(q == 18'h01000 + 18'(i), "R2 pre-rewind read", q, 18'h01000 + i);
    end
    rewind();
    chk(flags_ok == 1'b0, "R12 low at accept", flags_ok, 0);
    repeat (RT_CYC - 1) begin
      @(posedge rclk); #1;
      chk(flags_ok == 1'b0, "R12 low in window", flags_ok, 0);
    end
    @(posedge rclk); #1;
    chk(flags_ok == 1'b1, "R12 restored", flags_ok, 1);
    chk(empty == 1'b0, "R11 data available again", empty, 0);
    for (int i = 0; i < 6; i++) begin
      rd();
      chk(q == 18'h01000 + 18'(i), "R11 replay order", q, 18'h01000 + i);
    end
    chk(empty == 1'b1, "R11 empty after replay", empty, 1);

    @(negedge wclk); wen_n = 1'b0; d = 18'h0BEEF;
    idle(6);
    rewind();
    chk(flags_ok == 1'b1, "R11 rewind refused while writing", flags_ok, 1);
    @(negedge wclk) wen_n = 1'b1;
    idle(6);
    rd();
    chk(q == 18'h0BEEF, "R11 read continues after refusal", q, 18'h0BEEF);

    // R8 odd mode
    do_reset(1'b1);
    odd_sel = 1'b0;
    chk(pe == 2'b11, "R8 odd mode at reset word", pe, 2'b11);
    wr(18'h00000); wr(18'h00201); wr(18'h00403);
    idle(6);
    rd(); chk(pe == 2'b11, "R8 zero word odd mode", pe, 2'b11);
    rd(); chk(pe == 2'b00, "R8 single ones odd mode", pe, 2'b00);
    rd(); chk(pe == 2'b01, "R8 mixed lanes odd mode", pe, 2'b01);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge wclk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule